// File: doc/BRIEF.md
# CAN Physical-Layer Transceiver Control

This block is the digital decision logic that sits behind a CAN line driver and line receiver. Each clock it takes the transmit bit, a floating marker for that bit, the health of the logic-side and the bus-side supplies, and a die temperature code. From these it decides whether the driver pulls the high line up and the low line down (dominant) or leaves both lines at high impedance (recessive). It also reports when the driver outputs cannot be trusted.

On the receive side the block slices a digitized differential bus voltage, given in millivolts, into a received bit. It uses two thresholds. The bit holds its last value while the voltage sits between them. A bus with open inputs, or a bus side with no power, reads as recessive.

A thermal guard disables the driver once the die gets hot enough. It re-enables the driver only after the die has cooled by a set margin. Every output comes from a register, and reset leaves the driver recessive.

Top module: `can_phy_ctrl`

## Requirements
- R1: With both supplies good, the transmit bit low, the floating marker low and no thermal shutdown, the block drives dominant one cycle after sampling: `hi_drv_o`=1, `lo_drv_o`=1 and `bus_state_o`=2'b01.
- R2: A transmit bit that is high, or a raised floating marker, gives recessive one cycle later: both drive enables 0 and `bus_state_o`=2'b00.
- R3: With the logic-side supply off and the bus-side supply on, the outputs are recessive (2'b00, both enables 0) whatever the transmit bit is.
- R4: With the bus-side supply off, `bus_state_o`=2'b10 (indeterminate) and both drive enables are 0. This holds whatever the other inputs are.
- R5: With the bus side powered and the inputs connected, a differential voltage of 900 mV or more gives `rx_bit_o`=0 one cycle later. A voltage of 500 mV or less gives `rx_bit_o`=1.
- R6: A differential voltage from 501 mV to 899 mV leaves `rx_bit_o` at its previous value.
- R7: `rx_bit_o`=1 one cycle after the open-input marker is high or the bus-side supply is off, whatever the voltage is.
- R8: A die temperature of 150 °C or more sets the shutdown flag at that edge. From the following edge the driver stays recessive, so a hot sample shows at the port two cycles later.
- R9: A temperature of 140 °C or less clears the shutdown flag. A temperature from 141 °C to 149 °C leaves it unchanged, so the driver comes back only after cooling to 140 °C.
- R10: Synchronous reset gives both enables 0, `bus_state_o`=2'b00 and `rx_bit_o`=1, and clears the shutdown flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_bit_i | input | 1 | Transmit data bit (0 = dominant request) |
| tx_float_i | input | 1 | Transmit input is floating |
| logic_pwr_ok_i | input | 1 | Logic-side supply good |
| bus_pwr_ok_i | input | 1 | Bus-side supply good |
| bus_open_i | input | 1 | Bus inputs are open |
| diff_mv_i | input | DIFF_W (16) | Signed differential bus voltage, mV |
| die_temp_i | input | TEMP_W (9) | Signed die temperature, °C |
| hi_drv_o | output | 1 | Drive the high line up |
| lo_drv_o | output | 1 | Drive the low line down |
| bus_state_o | output | 2 | 00 recessive, 01 dominant, 10 indeterminate |
| rx_bit_o | output | 1 | Received data bit |

## Verification
The transmit path is tried with each supply combination crossed with a low, high and floating transmit bit. This separates the bus-supply override from the logic-supply override and from a plain recessive request. The receiver gets voltages exactly on 500 and 900 mV, inside the hold band after each bit value, negative values, and the open-input case; this separates the hold band from a single threshold and catches threshold rounding. The temperature runs up through 149 and 150 and back down through 141 and 140, so it shows both the hysteresis and the extra cycle of thermal latency. A reset applied while the driver is dominant confirms the recessive reset state.

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;
  typedef enum logic [1:0] {
    BUS_RECESSIVE = 2'b00,
    BUS_DOMINANT  = 2'b01,
    BUS_UNKNOWN   = 2'b10
  } bus_state_e;
endpackage

// File: rtl/can_thermal_guard.sv
module can_thermal_guard #(
  parameter int TEMP_W = 9,
  parameter int HOT_C  = 150,
  parameter int COOL_C = 140
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [TEMP_W-1:0] die_temp_i,
  output logic                     shdn_o
);
  localparam logic signed [TEMP_W-1:0] HOT_S  = TEMP_W'(HOT_C);
  localparam logic signed [TEMP_W-1:0] COOL_S = TEMP_W'(COOL_C);

  always_ff @(posedge clk) begin
    if (rst)                      shdn_o <= 1'b0;
    else if (die_temp_i >= HOT_S)  shdn_o <= 1'b1;
    else if (die_temp_i <= COOL_S) shdn_o <= 1'b0;
  end

  AST_SHDN_SET: assert property (@(posedge clk) disable iff (rst)
    (die_temp_i >= HOT_S) |=> shdn_o); // R8
  AST_SHDN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (die_temp_i <= COOL_S) |=> !shdn_o); // R9
  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (die_temp_i > COOL_S && die_temp_i < HOT_S) |=> $stable(shdn_o)); // R9
endmodule

// File: rtl/can_rx_slicer.sv
module can_rx_slicer #(
  parameter int DIFF_W = 16,
  parameter int DOM_MV = 900,
  parameter int REC_MV = 500
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_pwr_ok_i,
  input  logic                     bus_open_i,
  input  logic signed [DIFF_W-1:0] diff_mv_i,
  output logic                     rx_bit_o
);
  localparam logic signed [DIFF_W-1:0] DOM_S = DIFF_W'(DOM_MV);
  localparam logic signed [DIFF_W-1:0] REC_S = DIFF_W'(REC_MV);

  logic sense_ok;
  assign sense_ok = bus_pwr_ok_i && !bus_open_i;

  always_ff @(posedge clk) begin
    if (rst)                     rx_bit_o <= 1'b1;
    else if (!sense_ok)          rx_bit_o <= 1'b1;
    else if (diff_mv_i >= DOM_S) rx_bit_o <= 1'b0;
    else if (diff_mv_i <= REC_S) rx_bit_o <= 1'b1;
  end

  AST_RX_DOMINANT: assert property (@(posedge clk) disable iff (rst)
    (bus_pwr_ok_i && !bus_open_i && diff_mv_i >= DOM_S) |=> !rx_bit_o); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_pwr_ok_i && !bus_open_i && diff_mv_i > REC_S && diff_mv_i < DOM_S)
    |=> $stable(rx_bit_o)); // R6
  AST_RX_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!bus_pwr_ok_i || bus_open_i) |=> rx_bit_o); // R7
endmodule

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl
  import can_phy_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_bit_i,
  input  logic       tx_float_i,
  input  logic       logic_pwr_ok_i,
  input  logic       bus_pwr_ok_i,
  input  logic       shdn_i,
  output logic       hi_drv_o,
  output logic       lo_drv_o,
  output bus_state_e state_o
);
  bus_state_e state_d;

  always_comb begin
    if (!bus_pwr_ok_i)
      state_d = BUS_UNKNOWN;
    else if (!logic_pwr_ok_i || shdn_i || tx_float_i || tx_bit_i)
      state_d = BUS_RECESSIVE;
    else
      state_d = BUS_DOMINANT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o  <= BUS_RECESSIVE;
      hi_drv_o <= 1'b0;
      lo_drv_o <= 1'b0;
    end else begin
      state_o  <= state_d;
      hi_drv_o <= (state_d == BUS_DOMINANT);
      lo_drv_o <= (state_d == BUS_DOMINANT);
    end
  end

  AST_DOM_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
    (state_o == BUS_DOMINANT) |-> $past(logic_pwr_ok_i && bus_pwr_ok_i)); // R3
  AST_BUS_OFF_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
    !bus_pwr_ok_i |=> (state_o == BUS_UNKNOWN && !hi_drv_o && !lo_drv_o)); // R4
  AST_RECESSIVE_REQ: assert property (@(posedge clk) disable iff (rst)
    (bus_pwr_ok_i && (tx_bit_i || tx_float_i)) |=> (!hi_drv_o && !lo_drv_o)); // R2
endmodule

// File: rtl/can_phy_ctrl.sv
module can_phy_ctrl
  import can_phy_pkg::*;
#(
  parameter int DIFF_W = 16,
  parameter int TEMP_W = 9,
  parameter int DOM_MV = 900,
  parameter int REC_MV = 500,
  parameter int HOT_C  = 150,
  parameter int COOL_C = 140
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_bit_i,
  input  logic                     tx_float_i,
  input  logic                     logic_pwr_ok_i,
  input  logic                     bus_pwr_ok_i,
  input  logic                     bus_open_i,
  input  logic signed [DIFF_W-1:0] diff_mv_i,
  input  logic signed [TEMP_W-1:0] die_temp_i,
  output logic                     hi_drv_o,
  output logic                     lo_drv_o,
  output logic [1:0]               bus_state_o,
  output logic                     rx_bit_o
);
  logic       shdn;
  bus_state_e state;

  can_thermal_guard #(.TEMP_W(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C)) i_thermal (
    .clk        (clk),
    .rst        (rst),
    .die_temp_i (die_temp_i),
    .shdn_o     (shdn)
  );

  can_tx_ctrl i_tx (
    .clk            (clk),
    .rst            (rst),
    .tx_bit_i       (tx_bit_i),
    .tx_float_i     (tx_float_i),
    .logic_pwr_ok_i (logic_pwr_ok_i),
    .bus_pwr_ok_i   (bus_pwr_ok_i),
    .shdn_i         (shdn),
    .hi_drv_o       (hi_drv_o),
    .lo_drv_o       (lo_drv_o),
    .state_o        (state)
  );

  can_rx_slicer #(.DIFF_W(DIFF_W), .DOM_MV(DOM_MV), .REC_MV(REC_MV)) i_rx (
    .clk          (clk),
    .rst          (rst),
    .bus_pwr_ok_i (bus_pwr_ok_i),
    .bus_open_i   (bus_open_i),
    .diff_mv_i    (diff_mv_i),
    .rx_bit_o     (rx_bit_o)
  );

  assign bus_state_o = state;

  AST_NO_DRIVE_HOT: assert property (@(posedge clk) disable iff (rst)
    shdn |=> (bus_state_o != BUS_DOMINANT)); // R8
  AST_DOM_BOTH_LINES: assert property (@(posedge clk) disable iff (rst)
    (bus_state_o == BUS_DOMINANT) |-> (hi_drv_o && lo_drv_o)); // R1
endmodule

// File: tb/test_can_phy_ctrl.sv
module test_can_phy_ctrl;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tx_bit = 1'b1, tx_float = 1'b0, lok = 1'b1, bok = 1'b1, bopen = 1'b0;
  logic signed [15:0] diff_mv = '0;
  logic signed [8:0]  die_temp = 9'sd25;
  logic              hi_drv, lo_drv, rx_bit;
  logic [1:0]        bus_state;

  int checks = 0;
  int errors = 0;

  logic [1:0] e_state;
  logic       e_hi, e_lo, e_rx;
  logic       m_shdn = 1'b0;
  logic       m_rx = 1'b1;
  logic       have_exp = 1'b0;
  string      e_tag;

  always #5 clk = ~clk;

  can_phy_ctrl i_can_phy_ctrl (
    .clk(clk), .rst(rst), .tx_bit_i(tx_bit), .tx_float_i(tx_float),
    .logic_pwr_ok_i(lok), .bus_pwr_ok_i(bok), .bus_open_i(bopen),
    .diff_mv_i(diff_mv), .die_temp_i(die_temp),
    .hi_drv_o(hi_drv), .lo_drv_o(lo_drv), .bus_state_o(bus_state), .rx_bit_o(rx_bit)
  );

  task automatic check_all();
    checks++;
    if (bus_state !== e_state || hi_drv !== e_hi || lo_drv !== e_lo) begin
      errors++;
      $display("FAIL %s driver: state=%b hi=%b lo=%b expected state=%b hi=%b lo=%b",
               e_tag, bus_state, hi_drv, lo_drv, e_state, e_hi, e_lo);
    end
    checks++;
    if (rx_bit !== e_rx) begin
      errors++;
      $display("FAIL %s receiver: rx=%b expected %b", e_tag, rx_bit, e_rx);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic t, input logic f,
                      input logic lo_ok, input logic bu_ok, input logic op,
                      input int mv, input int temp);
    @(negedge clk);
    if (have_exp) check_all();
    rst = r; tx_bit = t; tx_float = f; lok = lo_ok; bok = bu_ok; bopen = op;
    diff_mv = 16'(mv); die_temp = 9'(temp);
    if (r) begin
      e_state = 2'b00; m_rx = 1'b1; m_shdn = 1'b0;
    end else begin
      if (!bu_ok) e_state = 2'b10;
      else if (!lo_ok || m_shdn || f || t) e_state = 2'b00;
      else e_state = 2'b01;
      if (!bu_ok || op) m_rx = 1'b1;
      else if (mv >= 900) m_rx = 1'b0;
      else if (mv <= 500) m_rx = 1'b1;
      if (temp >= 150) m_shdn = 1'b1;
      else if (temp <= 140) m_shdn = 1'b0;
    end
    e_hi = (e_state == 2'b01);
    e_lo = (e_state == 2'b01);
    e_rx = m_rx;
    e_tag = tag;
    have_exp = 1'b1;
  endtask

  initial begin
    step("R10", 1, 0, 0, 1, 1, 0, 2000, 25);
    step("R10", 1, 0, 0, 1, 1, 0, 2000, 25);
    step("R1",  0, 0, 0, 1, 1, 0, 2000, 25);
    step("R1",  0, 0, 0, 1, 1, 0, 1200, 60);
    step("R2",  0, 1, 0, 1, 1, 0, 100, 60);
    step("R2",  0, 0, 1, 1, 1, 0, 100, 60);
    step("R3",  0, 0, 0, 0, 1, 0, 100, 60);
    step("R3",  0, 1, 0, 0, 1, 0, 100, 60);
    step("R4",  0, 0, 0, 1, 0, 0, 2000, 60);
    step("R4",  0, 1, 1, 0, 0, 0, 2000, 60);
    step("R5",  0, 1, 0, 1, 1, 0, 900, 25);
    step("R5",  0, 1, 0, 1, 1, 0, 500, 25);
    step("R5",  0, 1, 0, 1, 1, 0, -300, 25);
    step("R5",  0, 1, 0, 1, 1, 0, 899, 25);
    step("R6",  0, 1, 0, 1, 1, 0, 501, 25);
    step("R5",  0, 1, 0, 1, 1, 0, 1500, 25);
    step("R6",  0, 1, 0, 1, 1, 0, 700, 25);
    step("R6",  0, 1, 0, 1, 1, 0, 501, 25);
    step("R7",  0, 1, 0, 1, 1, 1, 2000, 25);
    step("R5",  0, 1, 0, 1, 1, 0, 2000, 25);
    step("R7",  0, 1, 0, 1, 0, 0, 2000, 25);
    step("R6",  0, 1, 0, 1, 1, 0, 700, 25);
    step("R8",  0, 0, 0, 1, 1, 0, 2000, 149);
    step("R8",  0, 0, 0, 1, 1, 0, 2000, 150);
    step("R8",  0, 0, 0, 1, 1, 0, 2000, 145);
    step("R9",  0, 0, 0, 1, 1, 0, 2000, 141);
    step("R9",  0, 0, 0, 1, 1, 0, 2000, 140);
    step("R9",  0, 0, 0, 1, 1, 0, 2000, 100);
    step("R8",  0, 0, 0, 1, 1, 0, 2000, 200);
    step("R8",  0, 0, 0, 1, 1, 0, 2000, -40);
    step("R9",  0, 0, 0, 1, 1, 0, 2000, -40);
    step("R10", 1, 0, 0, 1, 1, 0, 2000, 25);
    step("R1",  0, 0, 0, 1, 1, 0, 2000, 25);
    step("R1",  0, 0, 0, 1, 1, 0, 2000, 25);
    @(negedge clk);
    check_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule